// File: doc/BRIEF.md
# Flash Bank Erase/Program Sequencer

This block erases or programs one bank of a byte-wide parallel flash device that reports progress through a status register. A host raises a one-cycle start with an operation code and a bank index. The block then issues the command bytes on the flash bus and polls the status register until the device reports ready. It sends the clear-status and return-to-array commands, and finally reads the entire bank back to confirm the result. Program data comes from a byte source port. The block presents an offset on that port and expects the matching image byte on the same cycle.

Each bank holds `BANK_BYTES` bytes (8192 by default). A bank's base address is its index times `BANK_BYTES`. The setup gap between a program command and its data byte is a count of `SETUP_CYC` clock cycles, which is 1 µs at 250 MHz by default. The poll budget per wait is `POLL_LIMIT` status reads. The block keeps busy high from the cycle after start until the cycle of its single done pulse, and it presents a 2-bit result code together with that pulse.

Top module: `flash_bank_seq`

## Requirements
- R1: While reset is held and after it is released with no start, busy_o, done_o, fl_we_o and fl_re_o are 0 and result_o is 0.
- R2: An erase writes 0x20 and then 0xD0, both to the bank base address (bank index × BANK_BYTES). op_i = 0 selects erase and op_i = 1 selects program.
- R3: Each status poll writes 0x70 to the bank base and then reads one status byte from the bank base. The device is ready when bit 7 of that byte is 1, and polling repeats until then.
- R4: For each byte in ascending offset order, a program writes 0x40 to the byte's address, waits exactly SETUP_CYC idle cycles, and writes the image byte to the same address. It then polls until ready before moving to the next byte.
- R5: If POLL_LIMIT consecutive status reads return not-ready, the operation stops with result 1 (timeout). The remaining program bytes and the read-back are skipped.
- R6: Every operation ends its flash traffic with 0x50 and then 0xFF, both written to the bank base.
- R7: After a clean erase, every byte in the bank must read 0xFF. After a clean program, every byte must equal the source image byte at the same offset. The first mismatch ends the read-back with result 2.
- R8: A ready status with any of bits 5:3 set (mask 0x38) stops the operation with result 3. The remaining bytes and the read-back are skipped.
- R9: busy_o stays high from the cycle after start until done_o. done_o lasts one cycle. result_o changes only together with done_o. A start raised while busy has no effect.
- R10: Let L be the not-ready reads per wait, N = BANK_BYTES and D = SETUP_CYC. A clean erase raises done L×2+N+7 cycles after the start edge, and a clean program raises it N×(2L+D+5)+3 cycles after. Mismatch, timeout and status-error runs shorten these totals by the steps they skip.
- R11: A successful result is 0, and bank contents outside the addressed bank are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request, sampled while idle |
| op_i | input | 1 | 0 = erase, 1 = program |
| bank_i | input | BANK_W | Bank index |
| src_addr_o | output | OFS_W | Offset of the requested image byte |
| src_data_i | input | 8 | Image byte at src_addr_o, same cycle |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_wdata_o | output | 8 | Flash write data / command |
| fl_we_o | output | 1 | Flash write strobe, one cycle per byte |
| fl_re_o | output | 1 | Flash read strobe; data sampled at the end of the cycle |
| fl_rdata_i | input | 8 | Flash read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 timeout, 2 verify mismatch, 3 status error |

## Verification
Every state of the sequencer lasts a fixed number of cycles. The cycle of done_o is therefore a closed formula in the not-ready count set in the bench's flash model, the setup count and the bank size. For each run, the bench counts rising edges from the start edge to the falling edge where done_o is seen, and compares that count with the formula for the expected path: clean, first-mismatch offset, timeout or status error. The flash model checks, at the write edge, that each data byte arrives exactly SETUP_CYC+1 cycles after its setup command. Bank contents, the command history and result_o are compared only after done_o.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_SETUP   = 4'd1,
        S_DELAY   = 4'd2,
        S_CONFIRM = 4'd3,
        S_PCMD    = 4'd4,
        S_PRD     = 4'd5,
        S_CLR     = 4'd6,
        S_RST     = 4'd7,
        S_VFY     = 4'd8,
        S_FIN     = 4'd9
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_TIMEOUT  = 2'd1,
        RES_MISMATCH = 2'd2,
        RES_STATUS   = 2'd3
    } seq_result_e;

    localparam logic [7:0] CMD_ERASE_ARM  = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
    localparam logic [7:0] CMD_PROG_ARM   = 8'h40;
    localparam logic [7:0] CMD_STAT_READ  = 8'h70;
    localparam logic [7:0] CMD_STAT_CLEAR = 8'h50;
    localparam logic [7:0] CMD_ARRAY_MODE = 8'hFF;
    localparam logic [7:0] STAT_READY     = 8'h80;
    localparam logic [7:0] STAT_FAULT     = 8'h38;
    localparam logic [7:0] ERASED_BYTE    = 8'hFF;

endpackage

// File: rtl/fsq_cycle_timer.sv
module fsq_cycle_timer #(
    parameter int unsigned LIMIT = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    generate
        if (LIMIT <= 1) begin : g_single
            // A one-count window is reached on its first cycle.
            assign hit_o = 1'b1;
        end else begin : g_count
            localparam int unsigned CW = $clog2(LIMIT);
            localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clr_i) begin
                    cnt_d = '0;
                end else if (inc_i && (cnt_q != TOP)) begin
                    cnt_d = cnt_q + CW'(1);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign hit_o = (cnt_q == TOP);
        end
    endgenerate
endmodule

// File: rtl/fsq_status_eval.sv
module fsq_status_eval (
    input  logic [7:0] stat_i,
    output logic       ready_o,
    output logic       fault_o
);
    import fsq_pkg::*;

    assign ready_o = |(stat_i & STAT_READY);
    assign fault_o = |(stat_i & STAT_FAULT);
endmodule

// File: rtl/fsq_bus_drive.sv
module fsq_bus_drive
    import fsq_pkg::*;
#(
    parameter int unsigned OFS_W  = 13,
    parameter int unsigned BANK_W = 1
) (
    input  seq_state_e              state_i,
    input  logic                    prog_i,
    input  logic [BANK_W-1:0]       bank_i,
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic [7:0]              src_i,
    output logic [OFS_W+BANK_W-1:0] addr_o,
    output logic [7:0]              wdata_o,
    output logic                    we_o,
    output logic                    re_o
);
    localparam int unsigned AW = OFS_W + BANK_W;

    logic [AW-1:0] base_addr;
    logic [AW-1:0] byte_addr;

    assign base_addr = {bank_i, {OFS_W{1'b0}}};
    assign byte_addr = {bank_i, ofs_i};

    always_comb begin
        addr_o  = base_addr;
        wdata_o = 8'h00;
        we_o    = 1'b0;
        re_o    = 1'b0;
        unique case (state_i)
            S_SETUP: begin
                we_o    = 1'b1;
                addr_o  = prog_i ? byte_addr : base_addr;
                wdata_o = prog_i ? CMD_PROG_ARM : CMD_ERASE_ARM;
            end
            S_CONFIRM: begin
                we_o    = 1'b1;
                addr_o  = prog_i ? byte_addr : base_addr;
                wdata_o = prog_i ? src_i : CMD_ERASE_GO;
            end
            S_PCMD: begin
                we_o    = 1'b1;
                wdata_o = CMD_STAT_READ;
            end
            S_PRD: begin
                re_o = 1'b1;
            end
            S_CLR: begin
                we_o    = 1'b1;
                wdata_o = CMD_STAT_CLEAR;
            end
            S_RST: begin
                we_o    = 1'b1;
                wdata_o = CMD_ARRAY_MODE;
            end
            S_VFY: begin
                re_o   = 1'b1;
                addr_o = byte_addr;
            end
            default: begin
                addr_o = base_addr;
            end
        endcase
    end
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
    import fsq_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 8192,
    parameter int unsigned BANKS      = 2,
    parameter int unsigned SETUP_CYC  = 250,
    parameter int unsigned POLL_LIMIT = 1000000,
    localparam int unsigned OFS_W  = $clog2(BANK_BYTES),
    localparam int unsigned BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int unsigned ADDR_W = OFS_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [OFS_W-1:0]  src_addr_o,
    input  logic [7:0]        src_data_i,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_wdata_o,
    output logic              fl_we_o,
    output logic              fl_re_o,
    input  logic [7:0]        fl_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o
);
    localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(BANK_BYTES - 1);
    localparam logic [OFS_W-1:0] OFS_ONE  = OFS_W'(1);

    typedef struct packed {
        seq_state_e        st;
        logic              prog;
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
        seq_result_e       code;
        seq_result_e       res;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic dly_clr, dly_inc, dly_hit;
    logic pol_clr, pol_inc, pol_hit;
    logic st_ready, st_fault;
    logic [7:0] vfy_expect;

    fsq_cycle_timer #(.LIMIT(SETUP_CYC)) u_setup_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (dly_clr),
        .inc_i (dly_inc),
        .hit_o (dly_hit)
    );

    fsq_cycle_timer #(.LIMIT(POLL_LIMIT)) u_poll_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (pol_clr),
        .inc_i (pol_inc),
        .hit_o (pol_hit)
    );

    fsq_status_eval u_status (
        .stat_i  (fl_rdata_i),
        .ready_o (st_ready),
        .fault_o (st_fault)
    );

    fsq_bus_drive #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_bus (
        .state_i (ctx_q.st),
        .prog_i  (ctx_q.prog),
        .bank_i  (ctx_q.bank),
        .ofs_i   (ctx_q.ofs),
        .src_i   (src_data_i),
        .addr_o  (fl_addr_o),
        .wdata_o (fl_wdata_o),
        .we_o    (fl_we_o),
        .re_o    (fl_re_o)
    );

    assign vfy_expect = ctx_q.prog ? src_data_i : ERASED_BYTE;

    always_comb begin
        ctx_d   = ctx_q;
        dly_clr = 1'b0;
        dly_inc = 1'b0;
        pol_clr = 1'b0;
        pol_inc = 1'b0;

        unique case (ctx_q.st)
            S_IDLE: begin
                if (start_i) begin
                    ctx_d.st   = S_SETUP;
                    ctx_d.prog = op_i;
                    ctx_d.bank = bank_i;
                    ctx_d.ofs  = '0;
                    ctx_d.code = RES_OK;
                end
            end
            S_SETUP: begin
                dly_clr  = 1'b1;
                ctx_d.st = ctx_q.prog ? S_DELAY : S_CONFIRM;
            end
            S_DELAY: begin
                dly_inc = 1'b1;
                if (dly_hit) ctx_d.st = S_CONFIRM;
            end
            S_CONFIRM: begin
                pol_clr  = 1'b1;
                ctx_d.st = S_PCMD;
            end
            S_PCMD: begin
                ctx_d.st = S_PRD;
            end
            S_PRD: begin
                if (st_ready) begin
                    if (st_fault) begin
                        ctx_d.code = RES_STATUS;
                        ctx_d.st   = S_CLR;
                    end else if (ctx_q.prog && (ctx_q.ofs != OFS_LAST)) begin
                        ctx_d.ofs = ctx_q.ofs + OFS_ONE;
                        ctx_d.st  = S_SETUP;
                    end else begin
                        ctx_d.st = S_CLR;
                    end
                end else if (pol_hit) begin
                    ctx_d.code = RES_TIMEOUT;
                    ctx_d.st   = S_CLR;
                end else begin
                    pol_inc  = 1'b1;
                    ctx_d.st = S_PCMD;
                end
            end
            S_CLR: begin
                ctx_d.st = S_RST;
            end
            S_RST: begin
                ctx_d.ofs = '0;
                ctx_d.st  = (ctx_q.code == RES_OK) ? S_VFY : S_FIN;
            end
            S_VFY: begin
                if (fl_rdata_i != vfy_expect) begin
                    ctx_d.code = RES_MISMATCH;
                    ctx_d.st   = S_FIN;
                end else if (ctx_q.ofs == OFS_LAST) begin
                    ctx_d.st = S_FIN;
                end else begin
                    ctx_d.ofs = ctx_q.ofs + OFS_ONE;
                end
            end
            S_FIN: begin
                ctx_d.st = S_IDLE;
            end
            default: begin
                ctx_d.st = S_IDLE;
            end
        endcase

        // The visible result moves together with the done pulse.
        if ((ctx_d.st == S_FIN) && (ctx_q.st != S_FIN)) begin
            ctx_d.res = ctx_d.code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q.st   <= S_IDLE;
            ctx_q.prog <= 1'b0;
            ctx_q.bank <= '0;
            ctx_q.ofs  <= '0;
            ctx_q.code <= RES_OK;
            ctx_q.res  <= RES_OK;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign src_addr_o = ctx_q.ofs;
    assign busy_o     = (ctx_q.st != S_IDLE);
    assign done_o     = (ctx_q.st == S_FIN);
    assign result_o   = ctx_q.res;
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       fl_we_o,
    input logic       fl_re_o,
    input logic [1:0] result_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!fl_we_o && !fl_re_o && !done_o)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_re_o)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R9

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R9

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(result_o))); // R9
endmodule

bind flash_bank_seq fsq_checker u_fsq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fl_we_o  (fl_we_o),
    .fl_re_o  (fl_re_o),
    .result_o (result_o)
);

// File: tb/tb_flash_bank_seq.sv
`timescale 1ns/1ps
module tb_flash_bank_seq;
    localparam int BB = 32;
    localparam int NB = 4;
    localparam int SC = 3;
    localparam int PL = 6;
    localparam int OW = $clog2(BB);
    localparam int BW = $clog2(NB);
    localparam int AW = OW + BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic [BW-1:0] bank_i = '0;
    logic [OW-1:0] src_addr_o;
    logic [7:0]    src_data_i;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_wdata_o;
    logic          fl_we_o, fl_re_o;
    logic [7:0]    fl_rdata_i;
    logic          busy_o, done_o;
    logic [1:0]    result_o;

    always #2 clk = ~clk;

    flash_bank_seq #(.BANK_BYTES(BB), .BANKS(NB), .SETUP_CYC(SC), .POLL_LIMIT(PL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .bank_i(bank_i),
        .src_addr_o(src_addr_o), .src_data_i(src_data_i),
        .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_we_o(fl_we_o),
        .fl_re_o(fl_re_o), .fl_rdata_i(fl_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // ---------------- source image ----------------
    logic [7:0] img [BB];
    assign src_data_i = img[src_addr_o];

    // ---------------- flash model ----------------
    logic [7:0] mem [NB*BB];
    logic [7:0] exp_mem [NB*BB];
    int  cyc = 0;
    bit  stat_mode = 0;
    int  lat_left = 0;
    int  lat_cfg = 0;
    bit  never_ready = 0;
    logic [7:0] fault_bits = 8'h00;
    int  stuck_idx = -1;
    int  pend = 0;            // 0 none, 1 erase armed, 2 program armed
    int  pend_addr = 0;
    int  pend_cyc = 0;
    int  cur_bank = 0;
    int  proto = 0;
    int  n_stat_cmd = 0;
    int  n_stat_rd = 0;
    bit  got_first = 0;
    int  first_addr = 0, first_data = 0;
    int  prev_addr = 0, prev_data = 0, last_addr = 0, last_data = 0;

    always_comb begin
        if (stat_mode)
            fl_rdata_i = (never_ready || lat_left > 0) ? 8'h00 : (8'h80 | fault_bits);
        else
            fl_rdata_i = mem[int'(fl_addr_o)];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fl_re_o && stat_mode) begin
            n_stat_rd <= n_stat_rd + 1;
            if (lat_left > 0) lat_left <= lat_left - 1;
        end
        if (fl_we_o) begin
            if (int'(fl_addr_o) / BB != cur_bank) proto <= proto + 1;
            if (!got_first) begin
                got_first <= 1; first_addr <= int'(fl_addr_o); first_data <= int'(fl_wdata_o);
            end
            prev_addr <= last_addr; prev_data <= last_data;
            last_addr <= int'(fl_addr_o); last_data <= int'(fl_wdata_o);
            if (pend == 2) begin
                if (int'(fl_addr_o) != pend_addr || cyc - pend_cyc != SC + 1) proto <= proto + 1;
                mem[int'(fl_addr_o)] <= mem[int'(fl_addr_o)] & fl_wdata_o;
                pend <= 0; stat_mode <= 1; lat_left <= lat_cfg;
            end else if (pend == 1) begin
                if (fl_wdata_o != 8'hD0 || int'(fl_addr_o) % BB != 0) proto <= proto + 1;
                for (int i = 0; i < BB; i++) begin
                    int a;
                    a = (int'(fl_addr_o) / BB) * BB + i;
                    mem[a] <= (a == stuck_idx) ? 8'h00 : 8'hFF;
                end
                pend <= 0; stat_mode <= 1; lat_left <= lat_cfg;
            end else begin
                case (fl_wdata_o)
                    8'h20: begin
                        pend <= 1;
                        if (int'(fl_addr_o) % BB != 0) proto <= proto + 1;
                    end
                    8'h40: begin pend <= 2; pend_addr <= int'(fl_addr_o); pend_cyc <= cyc; end
                    8'h70: begin
                        stat_mode <= 1; n_stat_cmd <= n_stat_cmd + 1;
                        if (int'(fl_addr_o) % BB != 0) proto <= proto + 1;
                    end
                    8'h50: ;
                    8'hFF: stat_mode <= 0;
                    default: proto <= proto + 1;
                endcase
            end
        end
    end

    // ---------------- bench bookkeeping ----------------
    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int busy_gaps = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_erase_ok(input int l);
        return 2 * l + BB + 7;
    endfunction
    function automatic int exp_prog_ok(input int l);
        return BB * (2 * l + SC + 5) + 3;
    endfunction

    task automatic run_op(input bit op, input int bank, input int lat, input bit poke);
        lat_cfg = lat; cur_bank = bank; proto = 0; n_stat_cmd = 0; n_stat_rd = 0;
        got_first = 0; busy_gaps = 0;
        @(negedge clk);
        start_i = 1; op_i = op; bank_i = BW'(bank);
        cycles = 0;
        do begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            start_i = 0;
            if (poke && cycles == 4) begin
                start_i = 1; op_i = ~op; bank_i = BW'((bank + 1) % NB);
            end
            if (!busy_o) busy_gaps++;
        end while (!done_o && cycles < 20000);
        start_i = 0;
    endtask

    task automatic chk_tail(input string req);
        chk(prev_data == 8'h50 && prev_addr == cur_bank * BB, req, prev_data, 8'h50);
        chk(last_data == 8'hFF && last_addr == cur_bank * BB, req, last_data, 8'hFF);
    endtask

    task automatic chk_mem(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < NB * BB; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic new_image();
        for (int i = 0; i < BB; i++) img[i] = 8'($urandom);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB * BB; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        for (int i = 0; i < BB; i++) img[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && !fl_we_o && !fl_re_o && result_o == 2'd0, "R1 in reset",
            int'({busy_o, done_o, fl_we_o, fl_re_o, result_o}), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !fl_we_o && !fl_re_o && result_o == 2'd0, "R1 after reset",
            int'({busy_o, done_o, fl_we_o, fl_re_o, result_o}), 0);

        // Clean erase of bank 1 (R2, R3, R6, R7, R10, R11)
        run_op(1'b0, 1, 2, 1'b0);
        for (int i = 0; i < BB; i++) exp_mem[BB + i] = 8'hFF;
        chk(result_o == 2'd0, "R11 erase result", result_o, 0);
        chk(cycles == exp_erase_ok(2), "R10 erase latency", cycles, exp_erase_ok(2));
        chk(first_data == 8'h20 && first_addr == BB, "R2 erase arm", first_data, 8'h20);
        chk(proto == 0, "R2 erase protocol", proto, 0);
        chk(n_stat_cmd == 3 && n_stat_rd == 3, "R3 poll count", n_stat_cmd, 3);
        chk_tail("R6 erase tail");
        chk_mem("R7 erase contents");
        chk(busy_gaps == 0, "R9 busy held", busy_gaps, 0);

        // Clean program of bank 1 with a start poke while busy (R4, R9)
        new_image();
        run_op(1'b1, 1, 1, 1'b1);
        for (int i = 0; i < BB; i++) exp_mem[BB + i] = img[i];
        chk(result_o == 2'd0, "R9 program result with ignored start", result_o, 0);
        chk(cycles == exp_prog_ok(1), "R10 program latency", cycles, exp_prog_ok(1));
        chk(proto == 0, "R4 setup gap and address", proto, 0);
        chk(n_stat_cmd == 2 * BB, "R4 poll per byte", n_stat_cmd, 2 * BB);
        chk_tail("R6 program tail");
        chk_mem("R11 program contents");
        chk(busy_gaps == 0, "R9 busy held", busy_gaps, 0);

        // Program without erase: read-back mismatch at offset 0 (R7)
        new_image();
        img[0] = 8'h5A;
        run_op(1'b1, 2, 0, 1'b0);
        chk(result_o == 2'd2, "R7 program mismatch code", result_o, 2);
        chk(cycles == BB * (SC + 4) + 4, "R10 mismatch latency", cycles, BB * (SC + 4) + 4);
        chk_mem("R11 after mismatch");

        // Erase with a stuck byte at offset 7 (R7)
        stuck_idx = 3 * BB + 7;
        run_op(1'b0, 3, 1, 1'b0);
        for (int i = 0; i < BB; i++) exp_mem[3 * BB + i] = (i == 7) ? 8'h00 : 8'hFF;
        stuck_idx = -1;
        chk(result_o == 2'd2, "R7 erase mismatch code", result_o, 2);
        chk(cycles == 2 * 1 + 7 + 8, "R10 stuck latency", cycles, 17);
        chk_mem("R7 stuck contents");

        // Never-ready erase: timeout (R5)
        never_ready = 1;
        run_op(1'b0, 0, 0, 1'b0);
        never_ready = 0;
        for (int i = 0; i < BB; i++) exp_mem[i] = 8'hFF;
        chk(result_o == 2'd1, "R5 timeout code", result_o, 1);
        chk(n_stat_rd == PL, "R5 poll budget", n_stat_rd, PL);
        chk(cycles == 2 * PL + 5, "R5 timeout latency", cycles, 2 * PL + 5);
        chk_tail("R6 timeout tail");

        // Status fault on the first programmed byte (R8)
        new_image();
        fault_bits = 8'h10;
        run_op(1'b1, 0, 2, 1'b0);
        fault_bits = 8'h00;
        exp_mem[0] = img[0];
        chk(result_o == 2'd3, "R8 status fault code", result_o, 3);
        chk(cycles == 2 * 2 + SC + 7, "R8 fault latency", cycles, 2 * 2 + SC + 7);
        chk_tail("R8 fault tail");
        chk_mem("R8 only first byte written");

        // Random erase/program pairs
        for (int it = 0; it < 16; it++) begin
            int b, l;
            b = int'($urandom % NB);
            l = int'($urandom % 4);
            run_op(1'b0, b, l, 1'b0);
            for (int i = 0; i < BB; i++) exp_mem[b * BB + i] = 8'hFF;
            chk(result_o == 2'd0 && cycles == exp_erase_ok(l), "R10 random erase",
                cycles, exp_erase_ok(l));
            new_image();
            l = int'($urandom % 3);
            run_op(1'b1, b, l, 1'b0);
            for (int i = 0; i < BB; i++) exp_mem[b * BB + i] = img[i];
            chk(result_o == 2'd0 && cycles == exp_prog_ok(l), "R10 random program",
                cycles, exp_prog_ok(l));
            chk(proto == 0, "R4 random protocol", proto, 0);
            chk_mem("R11 random contents");
        end

        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o, "R9 idle at end", int'(busy_o), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule